// File: doc/BRIEF.md
# Compressed Table-Jump Target Fetch Unit

This unit carries out the two compressed table-jump forms that share one 16-bit major encoding. When a matching instruction is presented while the unit is idle, it decodes the table index, forms the byte address of the table slot from a base register, and issues a single word read on a plain request/response memory port. When the word comes back, the unit emits a one-cycle redirect to the fetched target with its lowest bit forced to zero.

The encoding splits by index value. Small indexes, below 32, are plain jumps. Larger indexes, from 32 up, also write a return address into the link register (ra, x1). The unit reports itself busy from the cycle after it accepts an instruction until the read data arrives. While it is busy it ignores new instructions. Setting up the table base and checking its alignment are left to the surrounding core.

Top module: `tj_fetch`

## Requirements
- R1: After reset, `busy`, `rd_req`, `redir_valid` and `link_we` are all low.
- R2: An instruction is accepted when `instr_valid` is high, `busy` is low, bits [1:0] are 2'b10, bits [15:13] are 3'b101 and bits [12:10] are 3'b000. In the next cycle `rd_req` is high for exactly one cycle and `busy` is high.
- R3: When bits [12:7] are all zero, the instruction is a plain jump. Its index is bits [6:2] (0 to 31), and `rd_addr` equals `tbl_base + index*4` for the default 32-bit width.
- R4: When bits [12:10] are zero and bits [9:7] are not, the instruction is a link jump. Its index is bits [9:2] (32 to 255), and `rd_addr` equals `tbl_base + index*4`.
- R5: A word with wrong bits [1:0], wrong bits [15:13], or non-zero bits [12:10] is ignored: `busy` and `rd_req` stay low in the following cycle.
- R6: `busy` stays high from the request cycle through the cycle in which `rd_valid` is taken. Any `instr_valid` seen while `busy` is high is ignored, and no further `rd_req` is issued.
- R7: In the cycle after `rd_valid` is taken, `redir_valid` is high for exactly one cycle and `busy` is low. `redir_pc` equals `rd_data` with bit 0 cleared.
- R8: `link_we` is high only in the redirect cycle of a link jump, never for a plain jump. `link_data` then equals the instruction's `pc + 2`.
- R9: `rd_valid` is ignored unless a read is outstanding. A stray response while idle, or in the request cycle itself, produces no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Compressed instruction word |
| pc | input | XLEN | Address of the instruction |
| tbl_base | input | XLEN | Jump-table base address |
| busy | output | 1 | Accepted jump waiting for its table word |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | XLEN | Byte address of the table slot |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | XLEN | Fetched table word |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | XLEN | Redirect target, bit 0 cleared |
| link_we | output | 1 | Write ra this cycle |
| link_data | output | XLEN | Return address for ra |

## Verification
The read request is due one cycle after acceptance, together with `busy`. The redirect, and the link write if there is one, are due one cycle after the cycle in which `rd_valid` is taken. The response latency ranges from one cycle to several, and `busy` must hold across that whole window. The bench drives every input on the falling edge and samples at the next falling edge, one cycle per register stage. It checks the request cycle, each wait cycle, the redirect cycle and the cycle after it, so both a late pulse and a stretched pulse show up. Stray instructions are injected during the wait, and stray responses while idle and in the request cycle; each is checked at the ports one cycle later.

// File: rtl/tj_fetch.sv
module tj_fetch #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [15:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] tbl_base,
  output logic            busy,
  output logic            rd_req,
  output logic [XLEN-1:0] rd_addr,
  input  logic            rd_valid,
  input  logic [XLEN-1:0] rd_data,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_data
);
  localparam int IDXW = 8;
  localparam int WSH  = $clog2(XLEN/8);
  localparam logic [XLEN-1:0] CLR0 = {{(XLEN-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_t;
  st_t st;

  logic            is_tj, is_link, accept;
  logic [IDXW-1:0] idx;
  logic [XLEN-1:0] slot;
  logic [XLEN-1:0] addr_q, tgt_q, ret_q;
  logic            link_q;

  assign is_tj   = instr[1:0] == 2'b10 && instr[15:13] == 3'b101 && instr[12:10] == 3'b000;
  assign is_link = instr[9:7] != 3'b000;
  assign idx     = is_link ? instr[9:2] : {3'b000, instr[6:2]};
  assign slot    = tbl_base + ({{(XLEN-IDXW){1'b0}}, idx} << WSH);
  assign accept  = instr_valid && !busy && is_tj;

  assign busy        = st == S_REQ || st == S_WAIT;
  assign rd_req      = st == S_REQ;
  assign rd_addr     = addr_q;
  assign redir_valid = st == S_DONE;
  assign redir_pc    = tgt_q;
  assign link_we     = st == S_DONE && link_q;
  assign link_data   = ret_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      tgt_q  <= '0;
      ret_q  <= '0;
      link_q <= 1'b0;
    end else begin
      case (st)
        S_REQ:  st <= S_WAIT;
        S_WAIT: if (rd_valid) begin
                  st    <= S_DONE;
                  tgt_q <= rd_data & CLR0;
                end
        default: st <= accept ? S_REQ : S_IDLE;
      endcase
      if (accept) begin
        addr_q <= slot;
        link_q <= is_link;
        ret_q  <= pc + XLEN'(2);
      end
    end
  end
endmodule

module tj_fetch_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [15:0]     instr,
  input logic            busy,
  input logic            rd_req,
  input logic            rd_valid,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_pc,
  input logic            link_we
);
  logic ok_word;
  assign ok_word = instr[1:0] == 2'b10 && instr[15:13] == 3'b101 && instr[12:10] == 3'b000;

  a_r2_req_next: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !busy && ok_word) |=> rd_req);
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r6_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_valid) |=> busy);
  a_r7_redir_single: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);
  a_r7_redir_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(busy && rd_valid));
  a_r7_bit0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !redir_pc[0]);
  a_r8_link_in_redir: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> redir_valid);
  a_r9_no_idle_redir: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd_valid) |=> !redir_valid);
endmodule

bind tj_fetch tj_fetch_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
  .busy(busy), .rd_req(rd_req), .rd_valid(rd_valid),
  .redir_valid(redir_valid), .redir_pc(redir_pc), .link_we(link_we)
);

// File: tb/tj_fetch_bench.sv
module tj_fetch_bench;
  localparam int XLEN = 32;
  localparam time TCLK = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [15:0]     instr = '0;
  logic [XLEN-1:0] pc = '0, tbl_base = '0, rd_data = '0;
  logic            rd_valid = 1'b0;
  logic            busy, rd_req, redir_valid, link_we;
  logic [XLEN-1:0] rd_addr, redir_pc, link_data;

  int n_chk = 0, n_fail = 0;

  tj_fetch #(.XLEN(XLEN)) u_tj_fetch (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .pc(pc), .tbl_base(tbl_base), .busy(busy), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .link_we(link_we),
    .link_data(link_data)
  );

  always #(TCLK/2) clk = ~clk;

  function automatic logic [15:0] enc_plain(input logic [4:0] i);
    return {3'b101, 6'b000000, i, 2'b10};
  endfunction
  function automatic logic [15:0] enc_link(input logic [7:0] i);
    return {3'b101, 3'b000, i, 2'b10};
  endfunction
  function automatic logic [XLEN-1:0] exp_addr(input logic [XLEN-1:0] b, input int i);
    return b + XLEN'(i) * 4;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_jump(input logic lnk, input int idx, input logic [XLEN-1:0] p,
                          input logic [XLEN-1:0] b, input int lat,
                          input logic [XLEN-1:0] d, input logic stray);
    @(negedge clk);
    instr = lnk ? enc_link(8'(idx)) : enc_plain(5'(idx));
    pc = p; tbl_base = b; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(rd_req == 1'b1, "R2 rd_req", XLEN'(rd_req), 1);
    chk(busy == 1'b1, "R2 busy", XLEN'(busy), 1);
    chk(rd_addr == exp_addr(b, idx), lnk ? "R4 addr" : "R3 addr", rd_addr, exp_addr(b, idx));
    if (stray) rd_valid = 1'b1;
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      rd_valid = 1'b0;
      chk(busy == 1'b1 && rd_req == 1'b0 && redir_valid == 1'b0, "R6 waiting",
          {busy, rd_req, redir_valid}, 3'b100);
      if (stray) begin
        instr = enc_link(8'd40); tbl_base = '0; instr_valid = 1'b1;
      end
    end
    instr_valid = 1'b0;
    rd_valid = 1'b1; rd_data = d;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = $urandom;
    chk(redir_valid == 1'b1, "R7 redir_valid", XLEN'(redir_valid), 1);
    chk(busy == 1'b0, "R7 busy low", XLEN'(busy), 0);
    chk(redir_pc == (d & ~XLEN'(1)), "R7 redir_pc", redir_pc, d & ~XLEN'(1));
    chk(link_we == lnk, "R8 link_we", XLEN'(link_we), XLEN'(lnk));
    if (lnk) chk(link_data == p + 2, "R8 link_data", link_data, p + 2);
    @(negedge clk);
    chk(redir_valid == 1'b0 && link_we == 1'b0 && rd_req == 1'b0, "R7 single pulse",
        {redir_valid, link_we, rd_req}, 0);
  endtask

  task automatic try_bad(input logic [15:0] w, input string tag);
    @(negedge clk);
    instr = w; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(busy == 1'b0 && rd_req == 1'b0, tag, {busy, rd_req}, 0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(busy == 0 && rd_req == 0 && redir_valid == 0 && link_we == 0, "R1 reset",
        {busy, rd_req, redir_valid, link_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && rd_req == 0 && redir_valid == 0 && link_we == 0, "R1 after release",
        {busy, rd_req, redir_valid, link_we}, 0);

    run_jump(1'b0, 0, 32'h0000_1000, 32'h0000_8000, 1, 32'h0000_2001, 1'b0);
    run_jump(1'b0, 31, 32'h0000_1100, 32'h0001_0000, 3, 32'h0000_3000, 1'b0);
    run_jump(1'b1, 32, 32'hFFFF_FFFE, 32'h0002_0000, 1, 32'h0000_4003, 1'b0);
    run_jump(1'b1, 255, 32'h0000_2000, 32'hFFFF_FF00, 2, 32'h8000_0001, 1'b0);
    run_jump(1'b1, 100, 32'h0000_3000, 32'h0000_4000, 4, 32'h1234_5679, 1'b1);

    try_bad(16'b101_000_00000001_11, "R5 low bits");
    try_bad(16'b100_000_00000001_10, "R5 high bits");
    try_bad(16'b101_001_00000001_10, "R5 bits12:10");
    try_bad(16'b101_100_10000000_10, "R5 bit12");

    @(negedge clk);
    rd_valid = 1'b1; rd_data = 32'h0000_5555;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(redir_valid == 1'b0 && busy == 1'b0, "R9 idle response", {redir_valid, busy}, 0);

    for (int n = 0; n < 60; n++) begin
      logic lnk;
      int idx;
      lnk = 1'($urandom);
      idx = lnk ? 32 + int'($urandom_range(0, 223)) : int'($urandom_range(0, 31));
      run_jump(lnk, idx, $urandom & ~XLEN'(1), $urandom & ~XLEN'(3),
               int'($urandom_range(1, 5)), $urandom, 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule